// File: doc/BRIEF.md
# Page-Buffered Nonvolatile Write Sequencer

This block is the synchronous write controller of a byte-alterable nonvolatile memory model. Writes arrive as a valid/ready stream of address and data beats. The first beat opens a page. Further beats that share the same page number are collected in a page buffer, and each accepted beat restarts a load-window timer. A page has no overall time limit. When the window runs out with no new beat, the block enters a programming phase of fixed length. At the end of that phase it writes the loaded bytes into a register-array store in one step. Bytes of the page that were never loaded keep their old values.

Reads use a plain port with a one-cycle registered result. While programming is in progress, a read of the most recently written address returns that byte with its most significant bit inverted. A host can therefore poll a single bit to learn when the commit is done. Every other read returns the contents of the store.

The write stream follows these back-pressure rules. A beat transfers on a rising clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` does not depend on `wr_valid`. `wr_ready` is low for the whole programming phase. A source that presents a beat while `wr_ready` is low must hold it unchanged until it transfers.

Top module: `nvm_page_writer`

## Requirements
- R1: After reset, `busy` is 0, `page_err` is 0, `wr_ready` is 1, and every store byte reads 0xFF.
- R2: A beat transfers only on an edge with `wr_valid` and `wr_ready` both high. The first transferred beat of a page makes `busy` read 1 after that same edge.
- R3: Each transferred same-page beat restarts the load window. A beat that transfers at most LOAD_WIN edges after the previous one joins the page. Programming begins, and `wr_ready` drops, on the edge exactly LOAD_WIN edges after the last transferred beat of the page.
- R4: A page holds from 1 to PAGE_BYTES bytes, selected by the low log2(PAGE_BYTES) address bits. If one offset is written twice within a page, the later byte is committed.
- R5: A beat whose page number (the address bits above the offset) differs from the open page's is discarded and does not restart the window. `page_err` is set on the next edge and stays 1 until reset.
- R6: `wr_ready` stays 0 for the whole programming phase, and no beat transfers then. A beat held there transfers on the first edge after `wr_ready` returns to 1.
- R7: Programming lasts PROG_CYC edges. On its final edge, the loaded bytes are written into the store and `busy` returns to 0. Unloaded bytes of the page are unchanged.
- R8: A read sampled on an edge during programming, with its address equal to the last written address, returns the last written byte with bit DATA_W-1 inverted. This includes the final programming edge.
- R9: All other reads return the store contents. Bytes still in the page buffer, or not yet committed, are not visible.
- R10: `rd_data` is updated on the edge after `rd_en` is sampled high and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write beat present |
| wr_ready | output | 1 | Write beat can be taken |
| wr_addr | input | ADDR_W | Byte address of the beat |
| wr_data | input | DATA_W | Byte value of the beat |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | DATA_W | Registered read result |
| busy | output | 1 | A page is open or being programmed |
| page_err | output | 1 | Sticky: a beat from another page was discarded |

## Verification
A read of the last written address can fall on the same edge as the commit at the end of programming. The bench schedules a read to be sampled exactly on the computed final programming edge. It expects the inverted-MSB poll value, and expects the true byte from a read on the following edge. A second collision places a same-page beat on the very edge where the window expires. It also places one beat a single edge later, which must wait through a full programming phase. The transfer edges are then compared with the arithmetic from LOAD_WIN and PROG_CYC.

// File: rtl/nvm_pw_pkg.sv
package nvm_pw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } pw_state_e;
endpackage

// File: rtl/nvm_pw_timer.sv
module nvm_pw_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/nvm_pw_page_buf.sv
module nvm_pw_page_buf #(
  parameter int PAGE_BYTES = 16,
  parameter int DATA_W     = 8,
  localparam int OFS_W     = $clog2(PAGE_BYTES)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                ld,
  input  logic [OFS_W-1:0]                    ofs,
  input  logic [DATA_W-1:0]                   din,
  input  logic                                clr,
  output logic [PAGE_BYTES-1:0][DATA_W-1:0]   pg_data,
  output logic [PAGE_BYTES-1:0]               pg_mask
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_data <= '0;
      pg_mask <= '0;
    end else if (clr) begin
      pg_mask <= '0;
    end else if (ld) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (ofs == OFS_W'(i)) begin
          pg_data[i] <= din;
          pg_mask[i] <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/nvm_pw_store.sv
module nvm_pw_store #(
  parameter int MEM_BYTES  = 2048,
  parameter int PAGE_BYTES = 16,
  parameter int DATA_W     = 8,
  localparam int ADDR_W    = $clog2(MEM_BYTES),
  localparam int OFS_W     = $clog2(PAGE_BYTES),
  localparam int PG_W      = ADDR_W - OFS_W
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [PG_W-1:0]                   wr_page,
  input  logic [PAGE_BYTES-1:0][DATA_W-1:0] wr_bytes,
  input  logic [PAGE_BYTES-1:0]             wr_mask,
  input  logic [ADDR_W-1:0]                 rd_addr,
  output logic [DATA_W-1:0]                 rd_q
);
  logic [DATA_W-1:0] mem [MEM_BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < MEM_BYTES; j++) mem[j] <= '1;
    end else if (wr_en) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (wr_mask[i]) mem[{wr_page, OFS_W'(i)}] <= wr_bytes[i];
      end
    end
  end

  assign rd_q = mem[rd_addr];
endmodule

// File: rtl/nvm_page_writer.sv
module nvm_page_writer
  import nvm_pw_pkg::*;
#(
  parameter int MEM_BYTES  = 2048,
  parameter int PAGE_BYTES = 16,
  parameter int DATA_W     = 8,
  parameter int LOAD_WIN   = 2000,
  parameter int PROG_CYC   = 500000,
  localparam int ADDR_W    = $clog2(MEM_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              page_err
);
  localparam int OFS_W = $clog2(PAGE_BYTES);
  localparam int PG_W  = ADDR_W - OFS_W;
  localparam int MAXC  = (LOAD_WIN > PROG_CYC) ? LOAD_WIN : PROG_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  pw_state_e         state_q, state_d;
  logic [PG_W-1:0]   page_q;
  logic [ADDR_W-1:0] last_addr_q;
  logic [DATA_W-1:0] last_data_q;
  logic [DATA_W-1:0] rd_q;
  logic              tmr_load, tmr_exp;
  logic [CNT_W-1:0]  tmr_val;
  logic [PAGE_BYTES-1:0][DATA_W-1:0] pg_data;
  logic [PAGE_BYTES-1:0]             pg_mask;

  logic            beat, same_pg, take, drop, commit;
  logic [PG_W-1:0] in_pg;

  assign in_pg   = wr_addr[ADDR_W-1:OFS_W];
  assign beat    = wr_valid && wr_ready;
  assign same_pg = (state_q == ST_LOAD) && (in_pg == page_q);
  assign take    = beat && ((state_q == ST_IDLE) || same_pg);
  assign drop    = beat && (state_q == ST_LOAD) && !same_pg;
  assign commit  = (state_q == ST_PROG) && tmr_exp;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (take) state_d = ST_LOAD;
      ST_LOAD: if (!take && tmr_exp) state_d = ST_PROG;
      ST_PROG: if (tmr_exp) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign tmr_load = take || ((state_q == ST_LOAD) && tmr_exp);
  assign tmr_val  = take ? CNT_W'(LOAD_WIN - 1) : CNT_W'(PROG_CYC - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      page_q      <= '0;
      last_addr_q <= '0;
      last_data_q <= '0;
      page_err    <= 1'b0;
      rd_data     <= '0;
    end else begin
      state_q <= state_d;
      if (take && (state_q == ST_IDLE)) page_q <= in_pg;
      if (take) begin
        last_addr_q <= wr_addr;
        last_data_q <= wr_data;
      end
      if (drop) page_err <= 1'b1;
      if (rd_en) begin
        if ((state_q == ST_PROG) && (rd_addr == last_addr_q))
          rd_data <= {~last_data_q[DATA_W-1], last_data_q[DATA_W-2:0]};
        else
          rd_data <= rd_q;
      end
    end
  end

  assign wr_ready = (state_q != ST_PROG);
  assign busy     = (state_q != ST_IDLE);

  nvm_pw_timer #(.CNT_W(CNT_W)) tmr_i (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
  );

  nvm_pw_page_buf #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) buf_i (
    .clk(clk), .rst_n(rst_n), .ld(take), .ofs(wr_addr[OFS_W-1:0]), .din(wr_data),
    .clr(commit), .pg_data(pg_data), .pg_mask(pg_mask)
  );

  nvm_pw_store #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) store_i (
    .clk(clk), .rst_n(rst_n), .wr_en(commit), .wr_page(page_q), .wr_bytes(pg_data),
    .wr_mask(pg_mask), .rd_addr(rd_addr), .rd_q(rd_q)
  );
endmodule

// File: rtl/nvm_pw_chk.sv
module nvm_pw_chk
  import nvm_pw_pkg::*;
#(
  parameter int PG_W   = 7,
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [PG_W-1:0]   wr_page,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              busy,
  input logic              page_err,
  input pw_state_e         state,
  input logic [PG_W-1:0]   open_page,
  input logic [ADDR_W-1:0] last_addr,
  input logic              last_msb
);
  // R2
  a_r2_busy_after_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_valid && wr_ready) |=> busy);
  // R6
  a_r6_ready_low_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ready |-> busy);
  // R7
  a_r7_ready_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> wr_ready);
  // R5
  a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    page_err |=> page_err);
  // R5
  a_r5_foreign_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOAD && wr_valid && wr_ready && wr_page != open_page) |=> page_err);
  // R8
  a_r8_poll_inverts: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PROG && rd_en && rd_addr == last_addr) |=> (rd_data[DATA_W-1] != $past(last_msb)));
  // R10
  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

bind nvm_page_writer nvm_pw_chk #(.PG_W(PG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_page(wr_addr[ADDR_W-1:OFS_W]), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
  .busy(busy), .page_err(page_err), .state(state_q), .open_page(page_q),
  .last_addr(last_addr_q), .last_msb(last_data_q[DATA_W-1])
);

// File: tb/nvm_page_writer_tb.sv
`timescale 1ns/1ps
module nvm_page_writer_tb_top;
  localparam int MEMB = 64;
  localparam int PGB  = 4;
  localparam int LW   = 8;
  localparam int PC   = 20;
  localparam int AW   = 6;
  localparam int NPG  = MEMB / PGB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic wr_ready, busy, page_err;
  logic [7:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int last_acc = 0;
  logic [7:0] ref_mem [MEMB];
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  nvm_page_writer #(.MEM_BYTES(MEMB), .PAGE_BYTES(PGB), .DATA_W(8),
                    .LOAD_WIN(LW), .PROG_CYC(PC)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy), .page_err(page_err)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_at(logic [AW-1:0] a, logic [7:0] d, int t);
    @(negedge clk);
    while (cyc < t - 1) @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    while (!wr_ready) @(negedge clk);
    @(posedge clk); #1;
    last_acc = cyc;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic read_at(logic [AW-1:0] a, int t, output logic [7:0] q);
    @(negedge clk);
    while (cyc < t - 1) @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    q = rd_data;
  endtask

  task automatic edge_ready_low(output int e);
    while (wr_ready) @(negedge clk);
    e = cyc;
  endtask

  task automatic edge_idle(output int e);
    while (busy) @(negedge clk);
    e = cyc;
  endtask

  task automatic check_all(string req);
    logic [7:0] q;
    for (int a = 0; a < MEMB; a++) begin
      read_at(AW'(a), 0, q);
      chk(req, q, ref_mem[a]);
    end
  endtask

  initial begin
    logic [7:0] q;
    int e, a1, a2;
    for (int a = 0; a < MEMB; a++) ref_mem[a] = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 page_err", page_err, 0);
    chk("R1 wr_ready", wr_ready, 1);
    check_all("R1 store 0xFF");

    // R10 hold while rd_en low
    read_at(6'd9, 0, q);
    repeat (3) @(negedge clk);
    chk("R10 rd_data hold", rd_data, q);

    // R2/R3/R8/R7: poll read on the final programming edge
    chk("R2 busy before", busy, 0);
    put_at({4'd5, 2'd2}, 8'h3C, 0);
    chk("R2 busy after first beat", busy, 1);
    a1 = last_acc;
    edge_ready_low(e);
    chk("R3 program start edge", e, a1 + LW);
    read_at({4'd5, 2'd2}, a1 + LW + PC, q);
    chk("R8 poll on commit edge", q, 8'hBC);
    read_at({4'd5, 2'd2}, 0, q);
    chk("R7 true data after commit", q, 8'h3C);
    ref_mem[{4'd5, 2'd2}] = 8'h3C;
    chk("R7 busy low", busy, 0);

    // R4 repeated offset: last wins
    put_at({4'd3, 2'd1}, 8'hA5, 0);
    put_at({4'd3, 2'd1}, 8'h5A, 0);
    edge_idle(e);
    ref_mem[{4'd3, 2'd1}] = 8'h5A;
    read_at({4'd3, 2'd1}, 0, q);
    chk("R4 overwrite", q, 8'h5A);
    read_at({4'd3, 2'd0}, 0, q);
    chk("R7 unloaded byte kept", q, 8'hFF);

    // R3 boundary: beat exactly LW edges later joins; R9 read during load; R6 held beat
    put_at({4'd4, 2'd0}, 8'h40, 0);
    a1 = last_acc;
    read_at({4'd4, 2'd0}, 0, q);
    chk("R9 uncommitted byte invisible", q, 8'hFF);
    put_at({4'd4, 2'd1}, 8'h41, a1 + LW);
    a2 = last_acc;
    chk("R3 join edge", a2, a1 + LW);
    edge_ready_low(e);
    chk("R3 window restarted", e, a2 + LW);
    wr_valid = 1'b1; wr_addr = {4'd7, 2'd0}; wr_data = 8'h00;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R6 ready low in programming", wr_ready, 0);
    end
    wr_valid = 1'b0;
    edge_idle(e);
    chk("R7 commit edge", e, a2 + LW + PC);
    ref_mem[{4'd4, 2'd0}] = 8'h40;
    ref_mem[{4'd4, 2'd1}] = 8'h41;
    read_at({4'd7, 2'd0}, 0, q);
    chk("R6 held beat not taken", q, 8'hFF);
    read_at({4'd4, 2'd1}, 0, q);
    chk("R3 joined byte stored", q, 8'h41);

    // R3/R6 one edge past window: beat waits through programming
    put_at({4'd6, 2'd0}, 8'h60, 0);
    a1 = last_acc;
    put_at({4'd6, 2'd1}, 8'h61, a1 + LW + 1);
    chk("R6 late beat transfer edge", last_acc, a1 + LW + PC + 1);
    edge_idle(e);
    ref_mem[{4'd6, 2'd0}] = 8'h60;
    ref_mem[{4'd6, 2'd1}] = 8'h61;

    // Sweep all pages with varying byte masks (R3 R7 R8 R9)
    for (int p = 0; p < NPG; p++) begin
      int m;
      logic [AW-1:0] la;
      logic [7:0] ld, v;
      m = (p % 15) + 1;
      for (int i = 0; i < PGB; i++) begin
        if (m[i]) begin
          v = 8'((p * 29 + i * 83 + 7) & 255);
          put_at(AW'(p * PGB + i), v, 0);
          la = AW'(p * PGB + i);
          ld = v;
        end
      end
      a1 = last_acc;
      edge_ready_low(e);
      chk("R3 sweep program start", e, a1 + LW);
      read_at(la, 0, q);
      chk("R8 sweep poll", q, ld ^ 8'h80);
      read_at(la + 6'd1, 0, q);
      chk("R9 sweep other address", q, ref_mem[la + 6'd1]);
      edge_idle(e);
      chk("R7 sweep commit edge", e, a1 + LW + PC);
      for (int i = 0; i < PGB; i++)
        if (m[i]) ref_mem[p * PGB + i] = 8'((p * 29 + i * 83 + 7) & 255);
      check_all("R7 sweep store");
    end

    // R5 foreign page beat
    chk("R5 no error yet", page_err, 0);
    put_at({4'd1, 2'd0}, 8'h11, 0);
    a1 = last_acc;
    put_at({4'd2, 2'd1}, 8'h22, 0);
    chk("R5 err set", page_err, 1);
    edge_ready_low(e);
    chk("R5 window not restarted", e, a1 + LW);
    edge_idle(e);
    ref_mem[{4'd1, 2'd0}] = 8'h11;
    read_at({4'd2, 2'd1}, 0, q);
    chk("R5 dropped byte", q, ref_mem[{4'd2, 2'd1}]);
    read_at({4'd1, 2'd0}, 0, q);
    chk("R5 open page kept", q, 8'h11);
    repeat (4) @(negedge clk);
    chk("R5 err sticky", page_err, 1);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule